// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

A single-channel asynchronous serial port that sits in a small peripheral I/O space. A processor reaches it through five byte-wide registers: line configuration, transmit control/status, receive control/status, receive data and transmit data. Inside are a transmitter with one holding register and a shifter, a receiver with one holding register, bit timing derived from the system clock, and parity generation and checking.

The line format is set by software. It chooses the character length (5 to 8 bits, least significant bit first), parity (none, even or odd), one or two transmitted stop bits, and an oversampling divisor of 1, 16, 32 or 64. The divisor is multiplied by a fixed prescale count, so one bit lasts divisor × `PRESCALE` system clocks. The transmitter can also hold the line low for break, or drive a constant level chosen by software. Internal loopback routes the transmit line to the receiver and keeps the external pin idle. Each direction has its own interrupt request, which is level-sensitive.

The receive side keeps one character. A new character that completes while the previous one is still unread raises overrun, and the older byte is kept. Error flags stay set until software reads the receive status register.

Top module: `serial_port_regs`

## Requirements
- R1: The registers are decoded at byte offsets 0x10 (configuration), 0x12 (transmit control/status), 0x14 (receive control/status), 0x16 (receive data) and 0x18 (transmit data). After reset they read 0xC2, 0x81 and 0x80 for the first three. Any other offset reads 0x00.
- R2: Configuration bits 7:6 set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data is sent least significant bit first. Unused upper bits of a received byte read as 0.
- R3: Configuration bits 2:1 select the divisor: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64. Every serial bit lasts divisor × PRESCALE clocks.
- R4: Configuration bit 5 enables a parity bit after the data, and bit 4 picks even (1) or odd (0) parity. A received parity mismatch sets receive status bit 2.
- R5: Transmit control bit 4 set to 0 sends one stop bit and set to 1 sends two. With a byte waiting in the holding register, the next start bit follows the last stop bit with no gap.
- R6: Transmit status bit 0 (buffer empty) is 1 when the holding register can take a byte. A write to transmit data is dropped while that bit is 0 or while transmit enable (bit 7) is 0.
- R7: Transmit control bit 3 (break) holds the line low. Otherwise, bit 2 (force) drives the line to the level in bit 1. Break takes priority over force.
- R8: Configuration bit 0 (loopback) feeds the internal transmit line to the receiver and keeps the external TX pin at 1.
- R9: A received character sets receive status bit 4 (character available). Reading receive data returns it and clears that bit.
- R10: If a character completes while character available is still set, overrun (receive status bit 1) is set and the held byte is unchanged.
- R11: A stop bit sampled low sets framing error (receive status bit 3). Receive status bit 0 reads as the OR of bits 1 to 3. Reading the receive status register clears bits 1 to 3.
- R12: The receive request is high while receiver enable (bit 7), receive interrupt enable (bit 6) and character available are all set. The transmit request is high while transmit enable, transmit interrupt enable (bit 6) and buffer empty are all set.
- R13: Bit 5 of both status registers always reads 0. While receiver enable is 0, frames on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, triggers read side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench sweeps every character length, parity mode and stop-bit count through loopback, and checks the bit period for every divisor. A wrong divisor decode or a missing data mask would show up as a wrong start-bit width or as stray upper bits in the received byte. Two frames written back to back show whether stop bits are dropped or extra idle time is added. A write into a full holding register must not replace the byte already waiting, so the second frame has to carry the earlier value. Frames with a wrong parity bit, a low stop bit, or no read in between must set exactly one flag each. The overrun case also checks that the older byte survives.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

   localparam logic [7:0] OFS_CFG = 8'h10;
   localparam logic [7:0] OFS_TXC = 8'h12;
   localparam logic [7:0] OFS_RXC = 8'h14;
   localparam logic [7:0] OFS_RXD = 8'h16;
   localparam logic [7:0] OFS_TXD = 8'h18;

   localparam logic [7:0] CFG_RESET = 8'hC2;

   // packed in register bit order, MSB first
   typedef struct packed {
      logic [1:0] width;
      logic       par_en;
      logic       par_even;
      logic       clk_sel;
      logic [1:0] rate;
      logic       loop;
   } cfg_t;

   typedef struct packed {
      logic en;
      logic ie;
      logic stop2;
      logic brk;
      logic force_ch;
      logic fval;
   } txc_t;

   function automatic int unsigned rate_div(input logic [1:0] r);
      case (r)
         2'b00:   return 1;
         2'b01:   return 16;
         2'b10:   return 32;
         default: return 64;
      endcase
   endfunction

   function automatic logic [3:0] char_bits(input logic [1:0] w);
      return 4'd5 + {2'b00, w};
   endfunction

endpackage

// File: rtl/ser_tx.sv
module ser_tx
   import ser_port_pkg::*;
#(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    width,
   input  logic          par_en,
   input  logic          par_even,
   input  logic          stop2,
   input  logic [CW-1:0] bit_len,
   input  logic          wr,
   input  logic [7:0]    wdata,
   output logic          hold_full,
   output logic [7:0]    hold_q,
   output logic          line
);
   localparam int FW = 12;

   logic [FW-1:0] frame_c, shreg_q;
   logic [3:0]    total_c, left_q;
   logic [CW-1:0] cnt_q, len_q;
   logic          busy_q, last_tick, load;
   logic [3:0]    nb;
   logic [7:0]    dm;
   logic          par_bit;

   always_comb begin
      nb = char_bits(width);
      for (int i = 0; i < 8; i++) dm[i] = hold_q[i] & (4'(i) < nb);
      par_bit = par_even ? ^dm : ~^dm;
      frame_c = '1;
      frame_c[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (4'(i) < nb) frame_c[i+1] = dm[i];
      for (int i = 1; i < FW; i++)
         if (par_en && (4'(i) == nb + 4'd1)) frame_c[i] = par_bit;
      total_c = 4'd2 + nb + {3'b000, par_en} + {3'b000, stop2};
   end

   assign last_tick = busy_q && (cnt_q == len_q - 1'b1) && (left_q == 4'd1);
   assign load      = hold_full && en && (!busy_q || last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else if (wr && en && !hold_full) begin
         hold_full <= 1'b1;
         hold_q    <= wdata;
      end else if (load) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shreg_q <= '1;
         left_q  <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
      end else if (load) begin
         busy_q  <= 1'b1;
         shreg_q <= frame_c;
         left_q  <= total_c;
         cnt_q   <= '0;
         len_q   <= bit_len;
      end else if (busy_q) begin
         if (cnt_q == len_q - 1'b1) begin
            cnt_q   <= '0;
            shreg_q <= {1'b1, shreg_q[FW-1:1]};
            left_q  <= left_q - 4'd1;
            if (left_q == 4'd1) busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign line = busy_q ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/ser_rx.sv
module ser_rx
   import ser_port_pkg::*;
#(
   parameter int CW          = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    width,
   input  logic          par_en,
   input  logic          par_even,
   input  logic [CW-1:0] bit_len,
   input  logic          line_in,
   output logic          done,
   output logic [7:0]    data,
   output logic          par_err,
   output logic          frm_err
);
   typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} rx_state_t;

   logic          s_line, s_prev;
   rx_state_t     st_q;
   logic [CW-1:0] cnt_q, len_q;
   logic [3:0]    idx_q, nb_q, last_idx;
   logic          pen_q, even_q, pbit_q;
   logic [7:0]    sh_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign s_line = line_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy_q <= '1;
            else        sy_q <= {sy_q[SYNC_STAGES-2:0], line_in};
         end
         assign s_line = sy_q[SYNC_STAGES-1];
      end
   endgenerate

   assign last_idx = nb_q + {3'b000, pen_q} - 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_prev  <= 1'b1;
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         nb_q    <= 4'd8;
         pen_q   <= 1'b0;
         even_q  <= 1'b0;
         pbit_q  <= 1'b0;
         sh_q    <= '0;
         done    <= 1'b0;
         data    <= '0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         s_prev <= s_line;
         done   <= 1'b0;
         if (!en) begin
            st_q <= S_IDLE;
         end else begin
            case (st_q)
               S_IDLE: if (s_prev && !s_line) begin
                  st_q   <= S_START;
                  cnt_q  <= '0;
                  len_q  <= bit_len;
                  nb_q   <= char_bits(width);
                  pen_q  <= par_en;
                  even_q <= par_even;
               end
               S_START: begin
                  if (cnt_q == (len_q >> 1) - 1'b1) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     sh_q  <= '0;
                     st_q  <= s_line ? S_IDLE : S_BITS;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               S_BITS: begin
                  if (cnt_q == len_q - 1'b1) begin
                     cnt_q <= '0;
                     if (idx_q < nb_q) sh_q[idx_q[2:0]] <= s_line;
                     else              pbit_q <= s_line;
                     idx_q <= idx_q + 4'd1;
                     if (idx_q == last_idx) st_q <= S_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: begin
                  if (cnt_q == len_q - 1'b1) begin
                     cnt_q   <= '0;
                     st_q    <= S_IDLE;
                     done    <= 1'b1;
                     data    <= sh_q;
                     frm_err <= !s_line;
                     par_err <= pen_q && (pbit_q != (even_q ? ^sh_q : ~^sh_q));
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
   import ser_port_pkg::*;
#(
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       rx_irq,
   output logic       tx_irq
);
   localparam int MAX_LEN = 64 * PRESCALE;
   localparam int CW      = $clog2(MAX_LEN + 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   cfg_t          cfg_q;
   txc_t          txc_q;
   logic          rx_en_q, rx_ie_q;
   logic          rx_ca, rx_ove, rx_pe, rx_fe;
   logic [7:0]    rbuf_q;
   logic [CW-1:0] bit_len;

   logic wr_cfg, wr_txc, wr_rxc, wr_txd, rd_rxd, rd_rxs;
   logic hold_full, tx_line, line_int, rx_in, loop_on, brk_on;
   logic [7:0] hold_q, rx_data;
   logic rx_done, rx_perr, rx_ferr, ca_eff;

   assign wr_cfg = wr_en && (addr == OFS_CFG);
   assign wr_txc = wr_en && (addr == OFS_TXC);
   assign wr_rxc = wr_en && (addr == OFS_RXC);
   assign wr_txd = wr_en && (addr == OFS_TXD);
   assign rd_rxd = rd_en && (addr == OFS_RXD);
   assign rd_rxs = rd_en && (addr == OFS_RXC);

   always_comb begin
      bit_len = CW'(rate_div(cfg_q.rate) * PRESCALE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= cfg_t'(CFG_RESET);
         txc_q   <= '{en: 1'b1, default: 1'b0};
         rx_en_q <= 1'b1;
         rx_ie_q <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= cfg_t'(wdata);
         if (wr_txc) txc_q <= '{en: wdata[7], ie: wdata[6], stop2: wdata[4],
                                brk: wdata[3], force_ch: wdata[2], fval: wdata[1]};
         if (wr_rxc) begin
            rx_en_q <= wdata[7];
            rx_ie_q <= wdata[6];
         end
      end
   end

   ser_tx #(.CW(CW)) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (txc_q.en),
      .width    (cfg_q.width),
      .par_en   (cfg_q.par_en),
      .par_even (cfg_q.par_even),
      .stop2    (txc_q.stop2),
      .bit_len  (bit_len),
      .wr       (wr_txd),
      .wdata    (wdata),
      .hold_full(hold_full),
      .hold_q   (hold_q),
      .line     (tx_line)
   );

   assign loop_on  = cfg_q.loop;
   assign brk_on   = txc_q.brk;
   assign line_int = txc_q.brk ? 1'b0 : (txc_q.force_ch ? txc_q.fval : tx_line);
   assign txd      = loop_on ? 1'b1 : line_int;
   assign rx_in    = loop_on ? line_int : rxd;

   ser_rx #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en_q),
      .width   (cfg_q.width),
      .par_en  (cfg_q.par_en),
      .par_even(cfg_q.par_even),
      .bit_len (bit_len),
      .line_in (rx_in),
      .done    (rx_done),
      .data    (rx_data),
      .par_err (rx_perr),
      .frm_err (rx_ferr)
   );

   assign ca_eff = rx_ca && !rd_rxd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ca  <= 1'b0;
         rx_ove <= 1'b0;
         rx_pe  <= 1'b0;
         rx_fe  <= 1'b0;
         rbuf_q <= '0;
      end else begin
         if (rd_rxd) rx_ca <= 1'b0;
         if (rd_rxs) begin
            rx_ove <= 1'b0;
            rx_pe  <= 1'b0;
            rx_fe  <= 1'b0;
         end
         if (rx_done) begin
            if (ca_eff) begin
               rx_ove <= 1'b1;
            end else begin
               rx_ca  <= 1'b1;
               rbuf_q <= rx_data;
               if (rx_perr) rx_pe <= 1'b1;
               if (rx_ferr) rx_fe <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (addr)
         OFS_CFG: rdata = cfg_q;
         OFS_TXC: rdata = {txc_q.en, txc_q.ie, 1'b0, txc_q.stop2, txc_q.brk,
                           txc_q.force_ch, txc_q.fval, !hold_full};
         OFS_RXC: rdata = {rx_en_q, rx_ie_q, 1'b0, rx_ca, rx_fe, rx_pe, rx_ove,
                           rx_ove | rx_pe | rx_fe};
         OFS_RXD: rdata = rbuf_q;
         default: rdata = 8'h00;
      endcase
   end

   assign rx_irq = rx_en_q && rx_ie_q && rx_ca;
   assign tx_irq = txc_q.en && txc_q.ie && !hold_full;

endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk
   import ser_port_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       txd,
   input logic       loop_on,
   input logic       brk_on,
   input logic       rx_done,
   input logic       rx_ca,
   input logic       rx_ove,
   input logic       rx_pe,
   input logic       rx_fe,
   input logic [7:0] rbuf_q,
   input logic       rd_rxd,
   input logic       rd_rxs,
   input logic       wr_txd,
   input logic       hold_full,
   input logic [7:0] hold_q,
   input logic       rd_en,
   input logic [7:0] addr,
   input logic [7:0] rdata
);
   AST_LOOP_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) loop_on |-> txd); // R8
   AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (brk_on && !loop_on) |-> !txd); // R7
   AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_ca && rx_done && !rd_rxd) |=> (rx_ove && $stable(rbuf_q))); // R10
   AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_rxd && !rx_done) |=> !rx_ca); // R9
   AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_rxs && !rx_done) |=> !(rx_ove || rx_pe || rx_fe)); // R11
   AST_FULL_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (hold_full && wr_txd) |=> $stable(hold_q)); // R6
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && (addr == OFS_TXC || addr == OFS_RXC)) |-> !rdata[5]); // R13
endmodule

bind serial_port_regs ser_port_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .txd      (txd),
   .loop_on  (loop_on),
   .brk_on   (brk_on),
   .rx_done  (rx_done),
   .rx_ca    (rx_ca),
   .rx_ove   (rx_ove),
   .rx_pe    (rx_pe),
   .rx_fe    (rx_fe),
   .rbuf_q   (rbuf_q),
   .rd_rxd   (rd_rxd),
   .rd_rxs   (rd_rxs),
   .wr_txd   (wr_txd),
   .hold_full(hold_full),
   .hold_q   (hold_q),
   .rd_en    (rd_en),
   .addr     (addr),
   .rdata    (rdata)
);

// File: tb/serial_port_regs_tb_top.sv
module serial_port_regs_tb_top;
   localparam int PRE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rxd = 1'b1;
   logic       txd, rx_irq, tx_irq;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   serial_port_regs #(.PRESCALE(PRE)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !done_flag) begin
         done_flag = 1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
         report();
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_ca(input int limit);
      logic [7:0] s;
      for (int i = 0; i < limit; i++) begin
         peek(8'h14, s);
         if (s[4]) return;
      end
   endtask

   task automatic wait_low();
      for (int i = 0; i < 5000; i++) begin
         if (txd == 1'b0) return;
         @(negedge clk);
      end
   endtask

   task automatic tx_decode(input int nb, input int blen, input bit pen,
                            output logic [7:0] d, output logic pb, output logic sb);
      @(negedge clk);
      wait_low();
      d = '0;
      pb = 1'b0;
      repeat (blen / 2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         repeat (blen) @(negedge clk);
         d[i] = txd;
      end
      if (pen) begin
         repeat (blen) @(negedge clk);
         pb = txd;
      end
      repeat (blen) @(negedge clk);
      sb = txd;
   endtask

   task automatic rx_send(input logic [7:0] d, input int nb, input bit pen, input bit even,
                          input bit flip, input bit stopv, input int blen);
      logic p;
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (!even) p = ~p;
      if (flip)  p = ~p;
      @(negedge clk);
      rxd = 1'b0;
      repeat (blen) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = d[i];
         repeat (blen) @(negedge clk);
      end
      if (pen) begin
         rxd = p;
         repeat (blen) @(negedge clk);
      end
      rxd = stopv;
      repeat (blen) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * blen) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v, d, m;
      logic pb, sb;
      int cnt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values and map
      peek(8'h10, v); chk("R1 cfg reset", v, 8'hC2);
      peek(8'h12, v); chk("R1 txc reset", v, 8'h81);
      peek(8'h14, v); chk("R1 rxc reset", v, 8'h80);
      peek(8'h11, v); chk("R1 unmapped offset", v, 8'h00);
      chk("R12 irqs idle", {rx_irq, tx_irq}, 0);
      chk("R8 txd idle", txd, 1);

      // R13 reserved bit, R6 disabled transmitter drops write
      wr(8'h12, 8'hA0); peek(8'h12, v); chk("R13 txc reserved reads 0", v, 8'h81);
      wr(8'h14, 8'hA0); peek(8'h14, v); chk("R13 rxc reserved reads 0", v, 8'h80);
      wr(8'h12, 8'h00); wr(8'h18, 8'h55);
      repeat (4) @(negedge clk);
      peek(8'h12, v); chk("R6 write dropped while disabled", v, 8'h01);
      chk("R6 line stays idle", txd, 1);
      wr(8'h12, 8'h80);
      repeat (80) @(negedge clk);
      chk("R6 no frame after enabling", txd, 1);

      // R3 divisor sweep: start bit width
      for (int r = 0; r < 4; r++) begin
         int dv;
         dv = (r == 0) ? 1 : (r == 1) ? 16 : (r == 2) ? 32 : 64;
         wr(8'h10, {2'b11, 3'b000, r[1:0], 1'b0});
         fork
            begin
               wait_low();
               cnt = 0;
               while (txd == 1'b0) begin cnt++; @(negedge clk); end
            end
            wr(8'h18, 8'h01);
         join
         chk($sformatf("R3 bit period rate=%0d", r), cnt, dv * PRE);
         repeat (11 * dv * PRE) @(negedge clk);
      end

      // R2 R4 R5 R8 R9 loopback sweep at divisor 1
      for (int w = 0; w < 4; w++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int s = 0; s < 2; s++) begin
               d = 8'hA5 ^ 8'(w * 37 + pm * 11 + s * 90);
               m = 8'hFF >> (3 - w);
               wr(8'h10, {w[1:0], pm != 0, pm == 2, 1'b0, 2'b00, 1'b1});
               wr(8'h12, {3'b100, s[0], 4'b0000});
               wr(8'h18, d);
               @(negedge clk);
               chk("R8 loopback keeps pin high", txd, 1);
               wait_ca(200);
               rd(8'h14, v);
               chk($sformatf("R4 R9 status w=%0d p=%0d s=%0d", w, pm, s), v, 8'h90);
               rd(8'h16, v);
               chk($sformatf("R2 data w=%0d p=%0d s=%0d", w, pm, s), v, d & m);
               peek(8'h14, v);
               chk("R9 read clears available", v[4], 0);
               repeat (8 * PRE) @(negedge clk);
            end
         end
      end

      // R5 back-to-back spacing
      wr(8'h10, 8'hC0);
      for (int s = 0; s < 2; s++) begin
         wr(8'h12, {3'b100, s[0], 4'b0000});
         fork
            begin
               wait_low();
               cnt = 0;
               while (txd == 1'b0) begin cnt++; @(negedge clk); end
               while (txd == 1'b1) begin cnt++; @(negedge clk); end
            end
            begin
               wr(8'h18, 8'hFF);
               wr(8'h18, 8'hFF);
            end
         join
         chk($sformatf("R5 frame spacing stop2=%0d", s), cnt, (10 + s) * PRE);
         repeat (14 * PRE) @(negedge clk);
      end
      wr(8'h12, 8'h80);

      // R7 break and force
      wr(8'h10, 8'hC2);
      wr(8'h12, 8'h88); @(negedge clk); chk("R7 break low", txd, 0);
      wr(8'h12, 8'h86); @(negedge clk); chk("R7 force high", txd, 1);
      wr(8'h12, 8'h84); @(negedge clk); chk("R7 force low", txd, 0);
      wr(8'h12, 8'h8E); @(negedge clk); chk("R7 break beats force", txd, 0);
      wr(8'h12, 8'h80); @(negedge clk); chk("R7 release idle", txd, 1);

      // R2 R3 R4 external decode
      fork
         tx_decode(8, 16 * PRE, 0, d, pb, sb);
         wr(8'h18, 8'hA5);
      join
      chk("R3 decode 8N1 div16", d, 8'hA5);
      chk("R3 stop level", sb, 1);
      repeat (20 * PRE) @(negedge clk);
      wr(8'h10, 8'hB4);
      fork
         tx_decode(7, 32 * PRE, 1, d, pb, sb);
         wr(8'h18, 8'h3C);
      join
      chk("R2 decode 7 bits", d, 8'h3C);
      chk("R4 even parity bit", pb, ^(8'h3C));
      repeat (40 * PRE) @(negedge clk);
      wr(8'h10, 8'hA4);
      fork
         tx_decode(7, 32 * PRE, 1, d, pb, sb);
         wr(8'h18, 8'h15);
      join
      chk("R4 odd parity bit", pb, ~^(8'h15) & 1'b1);
      repeat (40 * PRE) @(negedge clk);

      // R6 full holding register
      wr(8'h10, 8'hC6);
      fork
         begin
            tx_decode(8, 64 * PRE, 0, d, pb, sb);
            chk("R6 first frame", d, 8'h12);
            tx_decode(8, 64 * PRE, 0, d, pb, sb);
            chk("R6 second frame keeps earlier byte", d, 8'h34);
         end
         begin
            wr(8'h18, 8'h12);
            wr(8'h18, 8'h34);
            peek(8'h12, v);
            chk("R6 buffer empty low", v[0], 0);
            wr(8'h18, 8'h56);
         end
      join
      repeat (64 * PRE) @(negedge clk);

      // R12 receive interrupt, R9
      wr(8'h10, 8'hC0);
      wr(8'h14, 8'hC0);
      rx_send(8'h5A, 8, 0, 0, 0, 1, PRE);
      chk("R12 rx irq asserted", rx_irq, 1);
      rd(8'h16, v); chk("R9 rx data", v, 8'h5A);
      @(negedge clk);
      chk("R12 rx irq cleared", rx_irq, 0);

      // R10 overrun and R11 clear
      rx_send(8'h11, 8, 0, 0, 0, 1, PRE);
      rx_send(8'h22, 8, 0, 0, 0, 1, PRE);
      rd(8'h14, v); chk("R10 overrun status", v, 8'hD3);
      rd(8'h14, v); chk("R11 status read clears", v, 8'hD0);
      rd(8'h16, v); chk("R10 older byte kept", v, 8'h11);

      // R4 parity error
      wr(8'h10, 8'hF0);
      rx_send(8'h33, 8, 1, 1, 1, 1, PRE);
      rd(8'h14, v); chk("R4 parity error", v, 8'hD5);
      rd(8'h16, v); chk("R4 data with parity error", v, 8'h33);

      // R11 framing error
      wr(8'h10, 8'hC0);
      rx_send(8'h44, 8, 0, 0, 0, 0, PRE);
      rd(8'h14, v); chk("R11 framing error", v, 8'hD9);
      rd(8'h16, v); chk("R11 data with framing error", v, 8'h44);

      // R13 receiver disabled
      wr(8'h14, 8'h00);
      rx_send(8'h77, 8, 0, 0, 0, 1, PRE);
      wr(8'h14, 8'h80);
      repeat (20) @(negedge clk);
      peek(8'h14, v); chk("R13 disabled receiver ignores frame", v, 8'h80);

      // R12 transmit interrupt
      wr(8'h12, 8'hC0); @(negedge clk); chk("R12 tx irq on", tx_irq, 1);
      wr(8'h12, 8'h40); @(negedge clk); chk("R12 tx irq needs enable", tx_irq, 0);

      done_flag = 1;
      report();
   end
endmodule